// File: doc/BRIEF.md
# Dual-Channel Playback Command Decoder

This block sits between a host byte port and two phrase playback engines. It takes command bytes one at a time, works out which operation each one asks for, and collects a second byte for the operations that need one. It then emits one-cycle control strobes and holds level controls for each channel. A two-bit mask in the first byte selects channel 1, channel 2 or both. Power-up and power-down requests, external-stream requests and flash-access requests go out as single-cycle strobes for the surrounding logic.

The block also builds the status byte that the host reads back. For each channel it carries an active-low busy flag and an active-low ready-for-command flag. These come from the engines' playing and queued indications, and all four flags are forced low while a command is in progress. The host marks the first byte of every command with `byte_first`. This lets the decoder tell a new command apart from an argument byte.

The controller is a three-state machine with a hold counter:
- `ST_IDLE`: no command is in progress.
- `ST_AWAIT_ARG`: a two-byte opcode has arrived and its argument is still outstanding.
- `ST_HOLD`: the command has executed and the flags are held low for `HOLD_CYCLES` clocks.

The transitions are:
- *launch-single*: any state to `ST_HOLD`, on a defined one-byte opcode.
- *launch-pair*: any state to `ST_AWAIT_ARG`, on a defined two-byte opcode.
- *argument*: `ST_AWAIT_ARG` to `ST_HOLD`.
- *abandon*: `ST_AWAIT_ARG` to `ST_IDLE`, on an undefined first byte.
- *release*: `ST_HOLD` to `ST_IDLE`, when the counter expires.

Top module: `dual_chan_cmd_decoder`

## Requirements
- R1: After reset, `status` reads 0x0F when both engines are idle, `loop_en` is 0, every strobe is low, and `phrase_num`, `sil_len` and `vol_val` are 0.
- R2: First-byte opcodes (byte bits 7:4) 0x0, 0x1, 0x2 and 0x3 pulse `pup_fast`, `pup_soft`, `pdn_fast` and `pdn_soft` respectively for one cycle. The pulse appears in the cycle after the byte is accepted.
- R3: Opcode 0x4 (play with phrase) waits for an argument byte. When the argument arrives, `play_start` and `phrase_load` pulse on the masked channels and `phrase_num` takes the argument. In the mask (byte bits 1:0), bit 0 selects channel 1 and bit 1 selects channel 2.
- R4: Opcode 0x5 (start) pulses `play_start` on the masked channels in the cycle after the byte. It does not pulse `phrase_load` and does not change `phrase_num`.
- R5: Opcode 0x6 with byte bits 3:2 equal to 00 takes an argument. It then pulses `phrase_load` only and updates `phrase_num`.
- R6: Opcode 0x7 (stop) pulses `stop_pulse` on the masked channels and clears `loop_en` for those channels in the same cycle.
- R7: Opcode 0x9 sets `loop_en` bits for the masked channels and opcode 0xA clears them. Channels that are not masked keep their loop setting.
- R8: Opcode 0x8 takes a length argument and opcode 0xB takes a volume argument. On the argument, 0x8 pulses `sil_load` and sets `sil_len` to the byte. 0xB pulses `vol_load` and sets `vol_val` to argument bits 4:0.
- R9: Opcodes 0xC and 0xD pulse `ext_req` and `flash_req` respectively, as one-byte commands.
- R10: `status` = {0,0,0,0,busy2_n,busy1_n,ncr2_n,ncr1_n}. Each busy flag is low when its channel is playing or a command is in progress. Each ready flag is low when its channel has a phrase queued or a command is in progress.
- R11: All four flags read low from the cycle after a defined first byte is accepted. They stay low while an argument is awaited, and for `HOLD_CYCLES` (4) cycles after the final byte.
- R12: The following are ignored: opcodes 0xE and 0xF, opcode 0x6 with nonzero bits 3:2, and a byte with `byte_first` low when no argument is awaited. An ignored byte produces no strobe and leaves flags, levels and held values unchanged. An undefined first byte while an argument is awaited drops the pending command and returns to idle.
- R13: A defined first byte that arrives while an argument is awaited replaces the pending command and is decoded as new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Byte strobe, one cycle per byte |
| byte_first | input | 1 | Marks the strobed byte as the first byte of a command |
| byte_in | input | 8 | Command or argument byte |
| ch_playing | input | 2 | Engine playing indication, bit 0 = channel 1 |
| ch_queued | input | 2 | Engine next-phrase-queued indication |
| pup_fast | output | 1 | Fast power-up strobe |
| pup_soft | output | 1 | Soft power-up strobe |
| pdn_fast | output | 1 | Fast power-down strobe |
| pdn_soft | output | 1 | Soft power-down strobe |
| play_start | output | 2 | Per-channel playback start strobe |
| phrase_load | output | 2 | Per-channel phrase address load strobe |
| phrase_num | output | 8 | Last phrase number received |
| stop_pulse | output | 2 | Per-channel stop strobe |
| sil_load | output | 2 | Per-channel silence insert strobe |
| sil_len | output | 8 | Last silence length received |
| vol_load | output | 2 | Per-channel volume load strobe |
| vol_val | output | 5 | Last volume received |
| loop_en | output | 2 | Per-channel loop mode |
| ext_req | output | 1 | External data streaming request strobe |
| flash_req | output | 1 | Flash access request strobe |
| status | output | 8 | Packed status byte |

## Verification
The bench targets the following corner cases:
- An argument that arrives several idle cycles late. A design with a timeout or one that counts the hold from the first byte would release the flags too early.
- A set-phrase byte with nonzero bits 3:2. A design that decodes only the upper nibble would wrongly pulse `phrase_load`.
- A stop on a looping channel. A design that fails to clear loop mode would leave `loop_en` high.
- A new first byte in place of an argument, and a stray argument byte. A design that treats every byte after a two-byte opcode as its argument would load the wrong phrase or volume.
- Engine indications that differ per channel, together with a both-channel mask. These expose swapped flag or mask bits in the status byte.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [3:0] {
        OP_PUP_FAST = 4'h0,
        OP_PUP_SOFT = 4'h1,
        OP_PDN_FAST = 4'h2,
        OP_PDN_SOFT = 4'h3,
        OP_PLAY     = 4'h4,
        OP_START    = 4'h5,
        OP_SETPH    = 4'h6,
        OP_STOP     = 4'h7,
        OP_SILENCE  = 4'h8,
        OP_LOOP_ON  = 4'h9,
        OP_LOOP_OFF = 4'hA,
        OP_VOLUME   = 4'hB,
        OP_EXT      = 4'hC,
        OP_FLASH    = 4'hD,
        OP_RSV_E    = 4'hE,
        OP_RSV_F    = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_AWAIT_ARG = 2'd1,
        ST_HOLD      = 2'd2
    } dec_state_e;

    typedef struct packed {
        opcode_e           op;
        logic [NUM_CH-1:0] mask;
        logic [7:0]        arg;
    } exec_req_t;

endpackage

// File: rtl/dcd_opcode_decode.sv
module dcd_opcode_decode
    import dcd_pkg::*;
(
    input  logic [7:0]        byte_in,
    output opcode_e           op,
    output logic [NUM_CH-1:0] mask,
    output logic              defined,
    output logic              two_byte
);

    always_comb begin
        op       = opcode_e'(byte_in[7:4]);
        mask     = byte_in[NUM_CH-1:0];
        defined  = 1'b1;
        two_byte = 1'b0;
        unique case (op)
            OP_PLAY, OP_SILENCE, OP_VOLUME: two_byte = 1'b1;
            OP_SETPH: begin
                two_byte = 1'b1;
                defined  = (byte_in[3:2] == 2'b00);
            end
            OP_RSV_E, OP_RSV_F: defined = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/dcd_fsm.sv
module dcd_fsm
    import dcd_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_first,
    input  logic [7:0]        byte_in,
    input  opcode_e           dec_op,
    input  logic [NUM_CH-1:0] dec_mask,
    input  logic              dec_defined,
    input  logic              dec_two_byte,
    output logic              proc_active,
    output logic              fire,
    output exec_req_t         req
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYCLES - 1);

    dec_state_e        st_q, st_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    opcode_e           pend_op_q, pend_op_d;
    logic [NUM_CH-1:0] pend_mask_q, pend_mask_d;

    logic new_cmd;
    logic arg_byte;

    assign new_cmd  = byte_vld && byte_first && dec_defined;
    assign arg_byte = byte_vld && !byte_first;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cnt_q       <= '0;
            pend_op_q   <= OP_PUP_FAST;
            pend_mask_q <= '0;
        end else begin
            st_q        <= st_d;
            cnt_q       <= cnt_d;
            pend_op_q   <= pend_op_d;
            pend_mask_q <= pend_mask_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d        = st_q;
        cnt_d       = cnt_q;
        pend_op_d   = pend_op_q;
        pend_mask_d = pend_mask_q;
        fire        = 1'b0;
        req.op      = dec_op;
        req.mask    = dec_mask;
        req.arg     = byte_in;
        unique case (st_q)
            ST_IDLE: begin
                if (new_cmd) begin
                    if (dec_two_byte) begin            // launch-pair
                        st_d        = ST_AWAIT_ARG;
                        pend_op_d   = dec_op;
                        pend_mask_d = dec_mask;
                    end else begin                     // launch-single
                        fire  = 1'b1;
                        st_d  = ST_HOLD;
                        cnt_d = HOLD_LOAD;
                    end
                end
            end
            ST_AWAIT_ARG: begin
                if (byte_vld && byte_first) begin
                    if (!dec_defined) begin            // abandon
                        st_d = ST_IDLE;
                    end else if (dec_two_byte) begin   // launch-pair
                        pend_op_d   = dec_op;
                        pend_mask_d = dec_mask;
                    end else begin                     // launch-single
                        fire  = 1'b1;
                        st_d  = ST_HOLD;
                        cnt_d = HOLD_LOAD;
                    end
                end else if (arg_byte) begin           // argument
                    fire     = 1'b1;
                    req.op   = pend_op_q;
                    req.mask = pend_mask_q;
                    st_d     = ST_HOLD;
                    cnt_d    = HOLD_LOAD;
                end
            end
            ST_HOLD: begin
                if (new_cmd) begin
                    if (dec_two_byte) begin
                        st_d        = ST_AWAIT_ARG;
                        pend_op_d   = dec_op;
                        pend_mask_d = dec_mask;
                    end else begin
                        fire  = 1'b1;
                        cnt_d = HOLD_LOAD;
                    end
                end else if (cnt_q == '0) begin        // release
                    st_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign proc_active = (st_q != ST_IDLE);

endmodule

// File: rtl/dcd_ctrl_regs.sv
module dcd_ctrl_regs
    import dcd_pkg::*;
#(
    parameter int VOL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  exec_req_t         req,
    output logic              pup_fast,
    output logic              pup_soft,
    output logic              pdn_fast,
    output logic              pdn_soft,
    output logic [NUM_CH-1:0] play_start,
    output logic [NUM_CH-1:0] phrase_load,
    output logic [7:0]        phrase_num,
    output logic [NUM_CH-1:0] stop_pulse,
    output logic [NUM_CH-1:0] sil_load,
    output logic [7:0]        sil_len,
    output logic [NUM_CH-1:0] vol_load,
    output logic [VOL_W-1:0]  vol_val,
    output logic [NUM_CH-1:0] loop_en,
    output logic              ext_req,
    output logic              flash_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pup_fast    <= 1'b0;
            pup_soft    <= 1'b0;
            pdn_fast    <= 1'b0;
            pdn_soft    <= 1'b0;
            play_start  <= '0;
            phrase_load <= '0;
            phrase_num  <= '0;
            stop_pulse  <= '0;
            sil_load    <= '0;
            sil_len     <= '0;
            vol_load    <= '0;
            vol_val     <= '0;
            loop_en     <= '0;
            ext_req     <= 1'b0;
            flash_req   <= 1'b0;
        end else begin
            pup_fast    <= 1'b0;
            pup_soft    <= 1'b0;
            pdn_fast    <= 1'b0;
            pdn_soft    <= 1'b0;
            play_start  <= '0;
            phrase_load <= '0;
            stop_pulse  <= '0;
            sil_load    <= '0;
            vol_load    <= '0;
            ext_req     <= 1'b0;
            flash_req   <= 1'b0;
            if (fire) begin
                unique case (req.op)
                    OP_PUP_FAST: pup_fast <= 1'b1;
                    OP_PUP_SOFT: pup_soft <= 1'b1;
                    OP_PDN_FAST: pdn_fast <= 1'b1;
                    OP_PDN_SOFT: pdn_soft <= 1'b1;
                    OP_PLAY: begin
                        play_start  <= req.mask;
                        phrase_load <= req.mask;
                        phrase_num  <= req.arg;
                    end
                    OP_START: play_start <= req.mask;
                    OP_SETPH: begin
                        phrase_load <= req.mask;
                        phrase_num  <= req.arg;
                    end
                    OP_STOP: begin
                        stop_pulse <= req.mask;
                        loop_en    <= loop_en & ~req.mask;
                    end
                    OP_SILENCE: begin
                        sil_load <= req.mask;
                        sil_len  <= req.arg;
                    end
                    OP_LOOP_ON:  loop_en <= loop_en | req.mask;
                    OP_LOOP_OFF: loop_en <= loop_en & ~req.mask;
                    OP_VOLUME: begin
                        vol_load <= req.mask;
                        vol_val  <= req.arg[VOL_W-1:0];
                    end
                    OP_EXT:   ext_req   <= 1'b1;
                    OP_FLASH: flash_req <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dcd_status_pack.sv
module dcd_status_pack
    import dcd_pkg::*;
(
    input  logic              proc_active,
    input  logic [NUM_CH-1:0] ch_playing,
    input  logic [NUM_CH-1:0] ch_queued,
    output logic [7:0]        status
);

    localparam int PAD_W = 8 - 2 * NUM_CH;

    logic [NUM_CH-1:0] busy_n;
    logic [NUM_CH-1:0] ready_n;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign busy_n[c]  = ~(proc_active | ch_playing[c]);
        assign ready_n[c] = ~(proc_active | ch_queued[c]);
    end

    assign status = {{PAD_W{1'b0}}, busy_n, ready_n};

endmodule

// File: rtl/dual_chan_cmd_decoder.sv
module dual_chan_cmd_decoder
    import dcd_pkg::*;
#(
    parameter int HOLD_CYCLES = 4,
    parameter int VOL_W       = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic       byte_first,
    input  logic [7:0] byte_in,
    input  logic [1:0] ch_playing,
    input  logic [1:0] ch_queued,
    output logic       pup_fast,
    output logic       pup_soft,
    output logic       pdn_fast,
    output logic       pdn_soft,
    output logic [1:0] play_start,
    output logic [1:0] phrase_load,
    output logic [7:0] phrase_num,
    output logic [1:0] stop_pulse,
    output logic [1:0] sil_load,
    output logic [7:0] sil_len,
    output logic [1:0] vol_load,
    output logic [4:0] vol_val,
    output logic [1:0] loop_en,
    output logic       ext_req,
    output logic       flash_req,
    output logic [7:0] status
);

    opcode_e           dec_op;
    logic [NUM_CH-1:0] dec_mask;
    logic              dec_defined;
    logic              dec_two_byte;
    logic              proc_active;
    logic              fire;
    exec_req_t         req;
    logic [VOL_W-1:0]  vol_int;

    dcd_opcode_decode u_decode (
        .byte_in  (byte_in),
        .op       (dec_op),
        .mask     (dec_mask),
        .defined  (dec_defined),
        .two_byte (dec_two_byte)
    );

    dcd_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld     (byte_vld),
        .byte_first   (byte_first),
        .byte_in      (byte_in),
        .dec_op       (dec_op),
        .dec_mask     (dec_mask),
        .dec_defined  (dec_defined),
        .dec_two_byte (dec_two_byte),
        .proc_active  (proc_active),
        .fire         (fire),
        .req          (req)
    );

    dcd_ctrl_regs #(.VOL_W(VOL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .req         (req),
        .pup_fast    (pup_fast),
        .pup_soft    (pup_soft),
        .pdn_fast    (pdn_fast),
        .pdn_soft    (pdn_soft),
        .play_start  (play_start),
        .phrase_load (phrase_load),
        .phrase_num  (phrase_num),
        .stop_pulse  (stop_pulse),
        .sil_load    (sil_load),
        .sil_len     (sil_len),
        .vol_load    (vol_load),
        .vol_val     (vol_int),
        .loop_en     (loop_en),
        .ext_req     (ext_req),
        .flash_req   (flash_req)
    );

    assign vol_val = 5'(vol_int);

    dcd_status_pack u_status (
        .proc_active (proc_active),
        .ch_playing  (ch_playing),
        .ch_queued   (ch_queued),
        .status      (status)
    );

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic       byte_first,
    input logic [7:0] byte_in,
    input logic [1:0] play_start,
    input logic [1:0] phrase_load,
    input logic [7:0] phrase_num,
    input logic [1:0] stop_pulse,
    input logic [1:0] sil_load,
    input logic [7:0] sil_len,
    input logic [1:0] vol_load,
    input logic [4:0] vol_val,
    input logic [1:0] loop_en,
    input logic [7:0] status
);

    AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] == 4'b0000) else $error("status pad bits set"); // R10

    AST_STOP_CLEARS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse != 2'b00) |-> ((loop_en & stop_pulse) == 2'b00))
        else $error("stop left loop enabled"); // R6

    AST_FLAGS_LOW_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((play_start | phrase_load | stop_pulse | sil_load | vol_load) != 2'b00)
        |-> (status[3:0] == 4'b0000)) else $error("flags high during command"); // R11

    AST_FLAGS_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((play_start | stop_pulse) != 2'b00) |=> (status[3:0] == 4'b0000))
        else $error("flags released early"); // R11

    AST_UNDEF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_first && byte_in[7:5] == 3'b111)
        |=> ((play_start | phrase_load | stop_pulse) == 2'b00))
        else $error("undefined opcode produced strobe"); // R12

    AST_PHRASE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phrase_num) |-> (phrase_load != 2'b00 || $past(byte_in[7:4]) inside {4'h4, 4'h6}))
        else $error("phrase changed without load"); // R3

    AST_SIL_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sil_len) |-> (sil_load != 2'b00 || !$past(byte_first)))
        else $error("silence length changed unexpectedly"); // R8

    AST_VOL_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vol_val) |-> (vol_load != 2'b00 || !$past(byte_first)))
        else $error("volume changed unexpectedly"); // R8

endmodule

bind dual_chan_cmd_decoder dcd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_first  (byte_first),
    .byte_in     (byte_in),
    .play_start  (play_start),
    .phrase_load (phrase_load),
    .phrase_num  (phrase_num),
    .stop_pulse  (stop_pulse),
    .sil_load    (sil_load),
    .sil_len     (sil_len),
    .vol_load    (vol_load),
    .vol_val     (vol_val),
    .loop_en     (loop_en),
    .status      (status)
);

// File: tb/dual_chan_cmd_decoder_test.sv
module dual_chan_cmd_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic       byte_first = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [1:0] ch_playing = 2'b00;
    logic [1:0] ch_queued = 2'b00;

    logic       pup_fast, pup_soft, pdn_fast, pdn_soft;
    logic [1:0] play_start, phrase_load, stop_pulse, sil_load, vol_load, loop_en;
    logic [7:0] phrase_num, sil_len, status;
    logic [4:0] vol_val;
    logic       ext_req, flash_req;

    dual_chan_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_first(byte_first),
        .byte_in(byte_in), .ch_playing(ch_playing), .ch_queued(ch_queued),
        .pup_fast(pup_fast), .pup_soft(pup_soft), .pdn_fast(pdn_fast), .pdn_soft(pdn_soft),
        .play_start(play_start), .phrase_load(phrase_load), .phrase_num(phrase_num),
        .stop_pulse(stop_pulse), .sil_load(sil_load), .sil_len(sil_len),
        .vol_load(vol_load), .vol_val(vol_val), .loop_en(loop_en),
        .ext_req(ext_req), .flash_req(flash_req), .status(status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";
    bit    done = 0;

    // behavioural reference state
    bit       m_wait = 0;
    int       m_hold = 0;
    int       m_op = 0;
    bit [1:0] m_mask = 0;
    bit [3:0] e_pwr = 0;          // {pdn_soft,pdn_fast,pup_soft,pup_fast}
    bit [1:0] e_play = 0, e_pload = 0, e_stop = 0, e_sil = 0, e_vol = 0, e_loop = 0;
    bit [7:0] e_phrase = 0, e_sillen = 0;
    bit [4:0] e_volval = 0;
    bit       e_ext = 0, e_flash = 0;

    function automatic bit is_pair(int op);
        return (op == 4) || (op == 6) || (op == 8) || (op == 11);
    endfunction

    task automatic run_cmd(int op, bit [1:0] mask, bit [7:0] arg);
        case (op)
            0: e_pwr[0] = 1;
            1: e_pwr[1] = 1;
            2: e_pwr[2] = 1;
            3: e_pwr[3] = 1;
            4: begin e_play = mask; e_pload = mask; e_phrase = arg; end
            5: e_play = mask;
            6: begin e_pload = mask; e_phrase = arg; end
            7: begin e_stop = mask; e_loop = e_loop & ~mask; end
            8: begin e_sil = mask; e_sillen = arg; end
            9: e_loop = e_loop | mask;
            10: e_loop = e_loop & ~mask;
            11: begin e_vol = mask; e_volval = arg[4:0]; end
            12: e_ext = 1;
            13: e_flash = 1;
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wait = 0; m_hold = 0; e_loop = 0; e_phrase = 0; e_sillen = 0; e_volval = 0;
            e_pwr = 0; e_play = 0; e_pload = 0; e_stop = 0; e_sil = 0; e_vol = 0;
            e_ext = 0; e_flash = 0;
        end else begin
            e_pwr = 0; e_play = 0; e_pload = 0; e_stop = 0; e_sil = 0; e_vol = 0;
            e_ext = 0; e_flash = 0;
            if (m_hold > 0) m_hold--;
            if (byte_vld && byte_first) begin
                int op;
                bit ok;
                op = int'(byte_in[7:4]);
                ok = (op <= 13) && !(op == 6 && byte_in[3:2] != 2'b00);
                if (ok) begin
                    if (is_pair(op)) begin
                        m_wait = 1; m_hold = 0; m_op = op; m_mask = byte_in[1:0];
                    end else begin
                        m_wait = 0; m_hold = HOLD;
                        run_cmd(op, byte_in[1:0], 8'h00);
                    end
                end else if (m_wait) begin
                    m_wait = 0;
                end
            end else if (byte_vld && m_wait) begin
                run_cmd(m_op, m_mask, byte_in);
                m_wait = 0; m_hold = HOLD;
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare on every falling edge, before inputs move
    always @(negedge clk) begin
        if (!done) begin
            bit       proc;
            bit [1:0] bn, rn;
            proc = m_wait || (m_hold > 0);
            bn = ~(ch_playing | {2{proc}});
            rn = ~(ch_queued | {2{proc}});
            chk("status", int'(status), int'({4'b0000, bn, rn}));
            chk("power", int'({pdn_soft, pdn_fast, pup_soft, pup_fast}), int'(e_pwr));
            chk("play_start", int'(play_start), int'(e_play));
            chk("phrase_load", int'(phrase_load), int'(e_pload));
            chk("phrase_num", int'(phrase_num), int'(e_phrase));
            chk("stop_pulse", int'(stop_pulse), int'(e_stop));
            chk("sil_load", int'(sil_load), int'(e_sil));
            chk("sil_len", int'(sil_len), int'(e_sillen));
            chk("vol_load", int'(vol_load), int'(e_vol));
            chk("vol_val", int'(vol_val), int'(e_volval));
            chk("loop_en", int'(loop_en), int'(e_loop));
            chk("ext_flash", int'({flash_req, ext_req}), int'({e_flash, e_ext}));
        end
    end

    task automatic send(bit first, bit [7:0] b);
        @(negedge clk); #1;
        byte_vld = 1; byte_first = first; byte_in = b;
        @(negedge clk); #1;
        byte_vld = 0; byte_first = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic engines(bit [1:0] p, bit [1:0] q);
        @(negedge clk); #1;
        ch_playing = p; ch_queued = q;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        tag = "R1";
        idle(3);
        @(negedge clk); #1; rst_n = 1;
        idle(3);
        chk("R1 reset status", int'(status), 8'h0F);

        tag = "R2";
        send(1, 8'h00); send(1, 8'h1F); send(1, 8'h25); send(1, 8'h3A); idle(6);

        tag = "R3";
        engines(2'b00, 2'b10);
        send(1, 8'h41); send(0, 8'h5A); idle(6);
        send(1, 8'h43); idle(3); send(0, 8'hC3); idle(6);

        tag = "R4";
        send(1, 8'h52); idle(6);

        tag = "R5";
        send(1, 8'h63); send(0, 8'h77); idle(6);
        send(1, 8'h67); send(0, 8'h11); idle(6);

        tag = "R6";
        send(1, 8'h93); idle(5); send(1, 8'h71); idle(6);

        tag = "R7";
        send(1, 8'h92); idle(5); send(1, 8'h91); idle(5); send(1, 8'hA2); idle(6);

        tag = "R8";
        send(1, 8'h83); send(0, 8'h40); idle(6);
        send(1, 8'hB1); send(0, 8'hFF); idle(6);
        send(1, 8'hB2); send(0, 8'h2C); idle(6);

        tag = "R9";
        send(1, 8'hC0); send(1, 8'hD0); idle(6);

        tag = "R10";
        engines(2'b01, 2'b10); idle(3);
        chk("R10 status mix", int'(status), 8'h09);
        engines(2'b10, 2'b01); idle(3);
        engines(2'b11, 2'b11); idle(3);
        engines(2'b00, 2'b00); idle(2);

        tag = "R11";
        send(1, 8'h73); send(1, 8'h50); send(1, 8'h81); idle(7); send(0, 8'h12); idle(2);
        chk("R11 held low", int'(status[3:0]), 0);
        idle(6);

        tag = "R12";
        engines(2'b01, 2'b00);
        send(1, 8'hE3); send(1, 8'hF1); send(0, 8'h99); idle(4);
        chk("R12 flags undisturbed", int'(status), 8'h0B);
        send(1, 8'h43); send(1, 8'hE0); send(0, 8'h33); idle(6);

        tag = "R13";
        engines(2'b00, 2'b00);
        send(1, 8'h41); send(1, 8'h93); idle(6);
        send(1, 8'h43); send(1, 8'h62); send(0, 8'h09); idle(6);
        send(1, 8'hB3); send(1, 8'h82); send(0, 8'h1E); idle(6);

        finish_run();
    end

endmodule